// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a virtual-to-physical translation after a TLB miss. It walks a two-level page table kept in memory. The requester supplies a 32-bit virtual address and the physical base of the top-level table (the directory). The walker then reads at most two 32-bit words through a simple request/response memory port. The first read fetches a directory entry. That entry locates one page-sized chunk of leaf entries, and the second read fetches one leaf entry from that chunk. The walker returns either a physical address or a fault.

Every table, the directory included, fills exactly one 4 KB page of 1024 four-byte entries. The virtual address therefore splits into three fields: a 10-bit directory index in bits 31:22, a 10-bit leaf index in bits 21:12 and a 12-bit page offset in bits 11:0. The offset passes through untranslated. An entry carries its valid flag in bit 0 and a 20-bit frame number in bits 31:12; bits 11:1 have no effect on the walk. When a directory entry is invalid, the rest of that entry carries no meaning, so the walk stops after one read.

The walker handles one walk at a time. It accepts a request only while idle and marks completion with a one-cycle pulse. The result stays on the outputs until the next walk completes. The memory may stall a request for any number of cycles and may answer after any delay.

Top module: `pt_walker`

## Requirements
- R1: While reset is high and in the first cycle after it, req_ready is 1, mem_req_valid is 0, done is 0, fault is 0 and paddr is 0.
- R2: req_ready is 1 only while no walk is in progress. A req_valid seen while busy is ignored and does not change the walk in progress.
- R3: The first memory read of a walk uses the address {req_dir_base[31:12], vaddr[31:22], 2'b00}. Bits 11:0 of req_dir_base have no effect.
- R4: If the directory entry has bit 0 clear, the walk ends with fault=1 and paddr=0, and no second memory read is issued.
- R5: If the directory entry has bit 0 set, the second read uses the address {dir_entry[31:12], vaddr[21:12], 2'b00}.
- R6: If the leaf entry has bit 0 clear, the walk ends with fault=1 and paddr=0.
- R7: If the leaf entry has bit 0 set, the walk ends with fault=0 and paddr={leaf_entry[31:12], vaddr[11:0]}.
- R8: A memory request stays asserted, with an unchanged address, until the cycle in which mem_req_ready is 1. Any number of stall cycles is allowed before the request is taken and before the response arrives.
- R9: mem_rsp_valid is ignored unless the walker is waiting for the response to a request it has already issued.
- R10: done is high for exactly one cycle: the cycle after the response that ends the walk. paddr and fault change only at the edge that raises done, and they hold their values until the next walk completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle; a request is taken this cycle |
| req_vaddr | input | 32 | Virtual address to translate |
| req_dir_base | input | 32 | Physical base of the directory page |
| mem_req_valid | output | 1 | Word read request to memory |
| mem_req_ready | input | 1 | Memory takes the read request |
| mem_req_addr | output | 32 | Byte address of the word to read |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Returned entry word |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Last walk hit an invalid entry |
| paddr | output | 32 | Physical address of the last walk (0 on fault) |

## Verification
Suppose the walker's state is wrong, for example it skips the leaf read, mistakes which read is in flight, or loses the latched request. The first sign at the ports is a memory request that is missing, extra or at the wrong address. This shows up in the cycle the request should appear, because the bench predicts mem_req_valid, mem_req_addr, req_ready and done for every clock. A corrupted frame number or offset shows up only at the done pulse, where paddr is compared against a translation the bench computes independently. Stray responses and requests sent while busy are injected so that state which wrongly accepts them produces a phase mismatch within one cycle.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    localparam int VA_W    = 32;
    localparam int OFS_W   = 12;
    localparam int ENT_LG  = 2;
    localparam int IDX_W   = OFS_W - ENT_LG;
    localparam int PFN_W   = VA_W - OFS_W;
    localparam int ATTR_W  = OFS_W - 1;

    typedef struct packed {
        logic [PFN_W-1:0]  pfn;
        logic [ATTR_W-1:0] attr;
        logic              valid;
    } entry_t;

    typedef struct packed {
        logic [IDX_W-1:0] dir_idx;
        logic [IDX_W-1:0] tbl_idx;
        logic [OFS_W-1:0] ofs;
    } vaddr_t;

    typedef struct packed {
        logic [VA_W-1:0] paddr;
        logic            fault;
    } result_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DIR_REQ,
        ST_DIR_WAIT,
        ST_LEAF_REQ,
        ST_LEAF_WAIT,
        ST_FINISH
    } walk_st_e;

    function automatic logic [VA_W-1:0] entry_addr(input logic [PFN_W-1:0] frame,
                                                   input logic [IDX_W-1:0] idx);
        return {frame, idx, {ENT_LG{1'b0}}};
    endfunction

endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
    import ptw_pkg::*;
(
    input  vaddr_t           va,
    input  logic [PFN_W-1:0] dir_frame,
    input  logic [PFN_W-1:0] leaf_frame,
    input  logic             sel_leaf,
    output logic [VA_W-1:0]  addr
);
    always_comb begin
        if (sel_leaf)
            addr = entry_addr(leaf_frame, va.tbl_idx);
        else
            addr = entry_addr(dir_frame, va.dir_idx);
    end
endmodule

// File: rtl/ptw_fsm.sv
module ptw_fsm
    import ptw_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     req_valid,
    input  logic     mem_req_ready,
    input  logic     mem_rsp_valid,
    input  logic     rsp_entry_valid,
    output walk_st_e st,
    output logic     accept,
    output logic     dir_take,
    output logic     walk_end,
    output logic     end_fault,
    output logic     mem_req_valid,
    output logic     sel_leaf
);
    walk_st_e nxt;

    always_comb begin
        nxt = st;
        unique case (st)
            ST_IDLE:      if (req_valid)     nxt = ST_DIR_REQ;
            ST_DIR_REQ:   if (mem_req_ready) nxt = ST_DIR_WAIT;
            ST_DIR_WAIT:  if (mem_rsp_valid) nxt = rsp_entry_valid ? ST_LEAF_REQ : ST_FINISH;
            ST_LEAF_REQ:  if (mem_req_ready) nxt = ST_LEAF_WAIT;
            ST_LEAF_WAIT: if (mem_rsp_valid) nxt = ST_FINISH;
            ST_FINISH:    nxt = ST_IDLE;
            default:      nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st <= ST_IDLE;
        else     st <= nxt;
    end

    always_comb begin
        accept        = (st == ST_IDLE) && req_valid;
        dir_take      = (st == ST_DIR_WAIT) && mem_rsp_valid && rsp_entry_valid;
        walk_end      = ((st == ST_DIR_WAIT) && mem_rsp_valid && !rsp_entry_valid) ||
                        ((st == ST_LEAF_WAIT) && mem_rsp_valid);
        end_fault     = !rsp_entry_valid;
        mem_req_valid = (st == ST_DIR_REQ) || (st == ST_LEAF_REQ);
        sel_leaf      = (st == ST_LEAF_REQ) || (st == ST_LEAF_WAIT);
    end

    // R9
    stray_rsp_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && mem_rsp_valid && !req_valid) |=> (st == ST_IDLE));

    // R2
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (st != ST_IDLE && st != ST_FINISH) |=> (st != ST_IDLE));
endmodule

// File: rtl/ptw_result.sv
module ptw_result
    import ptw_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            walk_end,
    input  logic            end_fault,
    input  logic [PFN_W-1:0] leaf_pfn,
    input  logic [OFS_W-1:0] ofs,
    output result_t         res
);
    always_ff @(posedge clk) begin
        if (rst) begin
            res <= '0;
        end else if (walk_end) begin
            res.fault <= end_fault;
            res.paddr <= end_fault ? '0 : {leaf_pfn, ofs};
        end
    end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import ptw_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [VA_W-1:0] req_vaddr,
    input  logic [VA_W-1:0] req_dir_base,
    output logic            mem_req_valid,
    input  logic            mem_req_ready,
    output logic [VA_W-1:0] mem_req_addr,
    input  logic            mem_rsp_valid,
    input  logic [VA_W-1:0] mem_rsp_data,
    output logic            done,
    output logic            fault,
    output logic [VA_W-1:0] paddr
);
    walk_st_e         st;
    logic             accept, dir_take, walk_end, end_fault, sel_leaf;
    vaddr_t           va_q;
    logic [PFN_W-1:0] base_q;
    logic [PFN_W-1:0] leaf_tbl_q;
    entry_t           rsp_ent;
    result_t          res;

    assign rsp_ent = entry_t'(mem_rsp_data);

    ptw_fsm u_fsm (
        .clk             (clk),
        .rst             (rst),
        .req_valid       (req_valid),
        .mem_req_ready   (mem_req_ready),
        .mem_rsp_valid   (mem_rsp_valid),
        .rsp_entry_valid (rsp_ent.valid),
        .st              (st),
        .accept          (accept),
        .dir_take        (dir_take),
        .walk_end        (walk_end),
        .end_fault       (end_fault),
        .mem_req_valid   (mem_req_valid),
        .sel_leaf        (sel_leaf)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            va_q       <= '0;
            base_q     <= '0;
            leaf_tbl_q <= '0;
        end else begin
            if (accept) begin
                va_q   <= vaddr_t'(req_vaddr);
                base_q <= req_dir_base[VA_W-1:OFS_W];
            end
            if (dir_take)
                leaf_tbl_q <= rsp_ent.pfn;
        end
    end

    ptw_addr_gen u_addr (
        .va         (va_q),
        .dir_frame  (base_q),
        .leaf_frame (leaf_tbl_q),
        .sel_leaf   (sel_leaf),
        .addr       (mem_req_addr)
    );

    ptw_result u_res (
        .clk       (clk),
        .rst       (rst),
        .walk_end  (walk_end),
        .end_fault (end_fault),
        .leaf_pfn  (rsp_ent.pfn),
        .ofs       (va_q.ofs),
        .res       (res)
    );

    assign req_ready = (st == ST_IDLE);
    assign done      = (st == ST_FINISH);
    assign fault     = res.fault;
    assign paddr     = res.paddr;

    // R8
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R10
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$stable(paddr) || !$stable(fault)) |-> done);

    // R2
    ready_not_done_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !req_ready);

    // R4
    dir_fault_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_DIR_WAIT && mem_rsp_valid && !mem_rsp_data[0])
            |=> (done && fault && !mem_req_valid));
endmodule

// File: tb/pt_walker_bench.sv
module pt_walker_bench;
    localparam int CLK_PERIOD = 10;
    localparam int N_WALKS    = 90;
    localparam int WATCHDOG   = 100000;

    logic        clk = 0;
    logic        rst = 1;
    logic        req_valid = 0;
    logic        req_ready;
    logic [31:0] req_vaddr = 0;
    logic [31:0] req_dir_base = 0;
    logic        mem_req_valid;
    logic        mem_req_ready = 0;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 0;
    logic [31:0] mem_rsp_data = 0;
    logic        done;
    logic        fault;
    logic [31:0] paddr;

    pt_walker u_pt_walker (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int errors = 0;
    int checks = 0;

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", rq, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        logic [31:0] h;
        h = (a ^ (a >> 13)) * 32'h9E3779B1;
        h = h ^ (h >> 16);
        return h;
    endfunction

    // model state: 0 idle, 1 dir request, 2 dir wait, 3 leaf request, 4 leaf wait, 5 finish
    int          ph = 0;
    int          walks = 0;
    int          mode = 0;
    logic [31:0] m_va, m_base, exp_addr, exp_paddr, last_paddr;
    logic        exp_fault, last_fault;
    int          fault_kind = 0;
    int          reads = 0;
    bit          pend = 0;
    int          cnt = 0;
    logic [31:0] pend_addr;
    bit          inj_prev = 0;
    int          n_dirf = 0, n_leaff = 0, n_ok = 0;
    int          cyc = 0;
    bit          finished = 0;

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        last_paddr = 0;
        last_fault = 0;
        repeat (3) @(negedge clk);
        // R1 during reset
        chk(req_ready == 1 && mem_req_valid == 0 && done == 0, "R1", {29'b0, req_ready, mem_req_valid, done}, 32'h4);
        @(negedge clk);
        rst = 0;
    end

    always @(negedge clk) begin
        cyc++;
        if (cyc > WATCHDOG && !finished) begin
            finished = 1;
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cyc, WATCHDOG);
            summary();
        end
        if (!rst && !finished) begin
            string lbl;
            lbl = inj_prev ? "R9" : "R8";
            if (cyc == 5) begin
                // R1 first cycle after reset
                chk(fault == 0 && paddr == 0 && req_ready == 1, "R1", paddr, 32'h0);
            end
            // ---------- per-cycle comparison ----------
            chk(req_ready == (ph == 0), inj_prev ? "R9" : "R2", {31'b0, req_ready}, {31'b0, ph == 0});
            chk(mem_req_valid == (ph == 1 || ph == 3), (fault_kind == 1 && ph == 5) ? "R4" : lbl,
                {31'b0, mem_req_valid}, {31'b0, ph == 1 || ph == 3});
            if (ph == 1 && mem_req_valid) chk(mem_req_addr == exp_addr, "R3", mem_req_addr, exp_addr);
            if (ph == 3 && mem_req_valid) chk(mem_req_addr == exp_addr, "R5", mem_req_addr, exp_addr);
            chk(done == (ph == 5), "R10", {31'b0, done}, {31'b0, ph == 5});
            if (ph == 5) begin
                string rq;
                rq = (fault_kind == 1) ? "R4" : (fault_kind == 2) ? "R6" : "R7";
                chk(fault == exp_fault, rq, {31'b0, fault}, {31'b0, exp_fault});
                chk(paddr == exp_paddr, rq, paddr, exp_paddr);
                if (fault_kind == 1) chk(reads == 1, "R4", reads, 1);
                else                 chk(reads == 2, "R5", reads, 2);
                last_paddr = exp_paddr;
                last_fault = exp_fault;
            end else begin
                chk(paddr == last_paddr && fault == last_fault, "R10", paddr, last_paddr);
            end

            // ---------- drive inputs for the next edge ----------
            inj_prev = 0;
            mem_rsp_valid = 0;
            mem_rsp_data = $urandom;
            if (pend) begin
                if (cnt == 0) begin
                    mem_rsp_valid = 1;
                    mem_rsp_data = mem_word(pend_addr);
                    pend = 0;
                end else cnt--;
            end else if ((ph == 0 || ph == 1) && ($urandom % 4 == 0)) begin
                // R9 stray response, valid bit set
                mem_rsp_valid = 1;
                mem_rsp_data = $urandom | 32'h1;
                inj_prev = 1;
            end
            case (mode)
                0:       mem_req_ready = 1;
                1:       mem_req_ready = ($urandom % 2) == 0;
                default: mem_req_ready = ($urandom % 8) == 0;
            endcase
            req_valid = 0;
            if (ph == 0) begin
                if (walks < N_WALKS && ($urandom % 3 != 0)) begin
                    req_valid = 1;
                    case (walks)
                        0: begin req_vaddr = 32'h0000_0000; req_dir_base = 32'h0001_0ABC; end
                        1: begin req_vaddr = 32'hFFFF_FFFF; req_dir_base = 32'hFFFF_F000; end
                        2: begin req_vaddr = 32'h1234_5678; req_dir_base = 32'h0040_0FFF; end
                        default: begin req_vaddr = $urandom; req_dir_base = $urandom; end
                    endcase
                end else if (walks >= N_WALKS) begin
                    finished = 1;
                    // R4 R6 R7 outcome coverage
                    chk(n_dirf > 0, "R4", n_dirf, 1);
                    chk(n_leaff > 0, "R6", n_leaff, 1);
                    chk(n_ok > 0, "R7", n_ok, 1);
                    summary();
                end
            end else begin
                // R2 requests while busy must be ignored
                req_valid = $urandom % 2;
                req_vaddr = $urandom;
                req_dir_base = $urandom;
            end

            // ---------- model transition at the next edge ----------
            case (ph)
                0: if (req_valid) begin
                    m_va = req_vaddr;
                    m_base = req_dir_base;
                    exp_addr = {m_base[31:12], m_va[31:22], 2'b00};
                    reads = 0;
                    mode = walks % 3;
                    walks++;
                    ph = 1;
                end
                1: if (mem_req_ready) begin
                    pend = 1; pend_addr = exp_addr; reads++;
                    cnt = (mode == 2) ? int'($urandom % 13) : int'($urandom % 3);
                    ph = 2;
                end
                2: if (mem_rsp_valid) begin
                    if (mem_rsp_data[0]) begin
                        exp_addr = {mem_rsp_data[31:12], m_va[21:12], 2'b00};
                        ph = 3;
                    end else begin
                        exp_fault = 1; exp_paddr = 0; fault_kind = 1; n_dirf++;
                        ph = 5;
                    end
                end
                3: if (mem_req_ready) begin
                    pend = 1; pend_addr = exp_addr; reads++;
                    cnt = (mode == 2) ? int'($urandom % 13) : int'($urandom % 3);
                    ph = 4;
                end
                4: if (mem_rsp_valid) begin
                    if (mem_rsp_data[0]) begin
                        exp_fault = 0; exp_paddr = {mem_rsp_data[31:12], m_va[11:0]};
                        fault_kind = 0; n_ok++;
                    end else begin
                        exp_fault = 1; exp_paddr = 0; fault_kind = 2; n_leaff++;
                    end
                    ph = 5;
                end
                default: ph = 0;
            endcase
        end
    end
endmodule